// File: doc/BRIEF.md
# Fault-Bypassing XY Mesh Route Selector

This block makes the routing decision for one router of a two-dimensional mesh. The router has four sides: north, east, south and west. There is no dedicated local port; a processing element can sit on any side, and an input tells the block which side that is. Flits arrive on each side and are stored in a small FIFO for that side. Switching is store-and-forward. An input competes for the output stage only after a whole packet, including its tail flit, is held in its FIFO.

A fixed-priority arbiter picks one competing input. The selector then routes that packet's header from the router's own coordinates, the packet's destination and a per-side availability mask. Normally it follows dimension order, X first and then Y. When the neighbour in that order is marked unavailable, it picks a detour direction locally. The chosen direction and the granted input are held until the tail flit has left. The flits stream out one per cycle on a registered output.

Top module: `mesh_route_sel`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is all ones.
- R2: Direction codes are north=0, east=1, south=2, west=3; bit d of `avail` marks side d as usable. With X unequal, the packet goes east if destination X is greater and west if smaller, provided that side is available; with X equal and Y unequal it goes north if destination Y is greater and south if smaller, provided that side is available.
- R3: When the preferred X side is unavailable, the packet goes toward the destination in Y if Y differs; otherwise north if available, else south if available, else it keeps the preferred X side.
- R4: When the preferred Y side is unavailable (X already equal), the packet goes east if available, else west if available, else it keeps the preferred Y side.
- R5: A packet whose destination equals the router's coordinates leaves on the side given by `local_side`.
- R6: Flit layout, MSB first: tail bit, destination X, destination Y, payload. No flit of a packet leaves its input before the packet's tail flit has been stored.
- R7: Among inputs holding a complete packet, north beats east, east beats south, and south beats west.
- R8: Once granted, a packet's flits leave in order on consecutive cycles with the same `out_dir` and `out_src`, and no other packet starts before its tail has left.
- R9: `in_ready` for a side is low while that side's FIFO holds DEPTH flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_x | input | XW | Router X coordinate |
| my_y | input | YW | Router Y coordinate |
| local_side | input | 2 | Side on which the local element is attached |
| avail | input | 4 | Per-side neighbour availability |
| in_valid | input | 4 | Per-side flit write strobe |
| in_flit | input | 4*FW | Per-side flit, side d at bits d*FW upward |
| in_ready | output | 4 | Per-side FIFO not full |
| out_valid | output | 1 | Forwarded flit valid |
| out_dir | output | 2 | Output side for the flit |
| out_src | output | 2 | Input side the flit came from |
| out_flit | output | FW | Forwarded flit |

## Verification
The hardest situation to reach is contention at one instant: all four inputs must finish a packet in the same cycle, so that priority decides the order and not arrival time. The stimulus writes equal-length packets into all four FIFOs in lock-step, so every tail is stored on the same edge. A second scenario delivers a new north packet while a west packet is already streaming out. This shows that the held grant outranks priority.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
  localparam int NSIDE = 4;
  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;
endpackage

// File: rtl/side_fifo.sv
module side_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic         has_pkt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, pkts;
  logic          acc_push, acc_pop, push_tail, pop_tail;

  assign full      = (cnt == (AW+1)'(DEPTH));
  assign empty     = (cnt == '0);
  assign has_pkt   = (pkts != '0);
  assign acc_push  = push && !full;
  assign acc_pop   = pop && !empty;
  assign dout      = mem[rp];
  assign push_tail = acc_push && din[W-1];
  assign pop_tail  = acc_pop && dout[W-1];

  always_ff @(posedge clk) begin
    if (acc_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      pkts <= '0;
    end else begin
      if (acc_push) wp <= (wp == LAST_IX) ? '0 : wp + 1'b1;
      if (acc_pop)  rp <= (rp == LAST_IX) ? '0 : rp + 1'b1;
      cnt  <= cnt + (AW+1)'(acc_push) - (AW+1)'(acc_pop);
      pkts <= pkts + (AW+1)'(push_tail) - (AW+1)'(pop_tail);
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/fixed_prio_arb.sv
module fixed_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] && !seen;
      seen   = seen || req[i];
    end
  end
endmodule

// File: rtl/xy_bypass_route.sv
module xy_bypass_route
  import mesh_route_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic [XW-1:0] my_x,
  input  logic [YW-1:0] my_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [3:0]    avail,
  input  logic [1:0]    local_side,
  output logic [1:0]    dir
);
  side_e pref;

  always_comb begin
    pref = SIDE_N;
    if (dst_x == my_x && dst_y == my_y) begin
      dir = local_side;
    end else if (dst_x != my_x) begin
      pref = (dst_x > my_x) ? SIDE_E : SIDE_W;
      if (avail[pref])          dir = pref;
      else if (dst_y != my_y)   dir = (dst_y > my_y) ? SIDE_N : SIDE_S;
      else if (avail[SIDE_N])   dir = SIDE_N;
      else if (avail[SIDE_S])   dir = SIDE_S;
      else                      dir = pref;
    end else begin
      pref = (dst_y > my_y) ? SIDE_N : SIDE_S;
      if (avail[pref])          dir = pref;
      else if (avail[SIDE_E])   dir = SIDE_E;
      else if (avail[SIDE_W])   dir = SIDE_W;
      else                      dir = pref;
    end
  end
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
  import mesh_route_pkg::*;
#(
  parameter int XW    = 3,
  parameter int YW    = 3,
  parameter int PW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [XW-1:0]             my_x,
  input  logic [YW-1:0]             my_y,
  input  logic [1:0]                local_side,
  input  logic [3:0]                avail,
  input  logic [3:0]                in_valid,
  input  logic [4*(1+XW+YW+PW)-1:0] in_flit,
  output logic [3:0]                in_ready,
  output logic                      out_valid,
  output logic [1:0]                out_dir,
  output logic [1:0]                out_src,
  output logic [(1+XW+YW+PW)-1:0]   out_flit
);
  localparam int FW = 1 + XW + YW + PW;

  logic [FW-1:0] head [NSIDE];
  logic [3:0]    req, gnt, pop, full, empty;
  logic          busy;
  logic [1:0]    g_src, win, route_dir, dir_q;
  logic [FW-1:0] win_head, cur_head;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    side_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .push(in_valid[s]), .din(in_flit[s*FW +: FW]),
      .pop(pop[s]), .dout(head[s]),
      .full(full[s]), .empty(empty[s]), .has_pkt(req[s])
    );
    assign pop[s]      = busy && (g_src == 2'(s));
    assign in_ready[s] = !full[s];
  end

  fixed_prio_arb #(.N(NSIDE)) u_arb (.req(req), .gnt(gnt));

  always_comb begin
    win = 2'd0;
    for (int s = NSIDE - 1; s >= 0; s--) begin
      if (gnt[s]) win = 2'(s);
    end
  end

  assign win_head = head[win];
  assign cur_head = head[g_src];

  xy_bypass_route #(.XW(XW), .YW(YW)) u_route (
    .my_x(my_x), .my_y(my_y),
    .dst_x(win_head[FW-2 -: XW]),
    .dst_y(win_head[FW-2-XW -: YW]),
    .avail(avail), .local_side(local_side),
    .dir(route_dir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      g_src     <= '0;
      dir_q     <= '0;
      out_valid <= 1'b0;
      out_dir   <= '0;
      out_src   <= '0;
      out_flit  <= '0;
    end else if (!busy) begin
      out_valid <= 1'b0;
      if (|req) begin
        busy  <= 1'b1;
        g_src <= win;
        dir_q <= route_dir;
      end
    end else begin
      out_valid <= 1'b1;
      out_flit  <= cur_head;
      out_dir   <= dir_q;
      out_src   <= g_src;
      if (cur_head[FW-1]) busy <= 1'b0;
    end
  end

  a_r7_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt == '0) == (req == '0)));
  a_r8_hold_route: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_flit[FW-1]) |=> (out_valid && $stable(out_dir) && $stable(out_src)));
  a_r6_pop_has_packet: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> req[g_src]);
endmodule

// File: tb/mesh_route_sel_test.sv
`timescale 1ns/1ps
module mesh_route_sel_test;
  localparam int XW = 3, YW = 3, PW = 8, DEPTH = 8;
  localparam int FW = 1 + XW + YW + PW;

  logic clk = 0, rst = 1;
  logic [XW-1:0] my_x = 3;
  logic [YW-1:0] my_y = 3;
  logic [1:0] local_side = 2'd2;
  logic [3:0] avail = 4'hF;
  logic [3:0] in_valid = '0;
  logic [4*FW-1:0] in_flit = '0;
  logic [3:0] in_ready;
  logic out_valid;
  logic [1:0] out_dir, out_src;
  logic [FW-1:0] out_flit;

  int errors = 0, checks = 0, log_n = 0;
  logic [1:0] log_dir [256];
  logic [1:0] log_src [256];
  logic [FW-1:0] log_flit [256];

  mesh_route_sel #(.XW(XW), .YW(YW), .PW(PW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .my_x(my_x), .my_y(my_y), .local_side(local_side),
    .avail(avail), .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_dir(out_dir), .out_src(out_src), .out_flit(out_flit));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && out_valid && log_n < 256) begin
      log_dir[log_n]  <= out_dir;
      log_src[log_n]  <= out_src;
      log_flit[log_n] <= out_flit;
      log_n <= log_n + 1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_pkt(int s, int dx, int dy, int len, int base, bit tail = 1);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = '0;
      in_valid[s] = 1'b1;
      in_flit[s*FW +: FW] = {(tail && i == len - 1), 3'(dx), 3'(dy), 8'(base + i)};
    end
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic expect_pkt(int at, int src, int dir, int len, int base, string req);
    check(log_n >= at + len, req, log_n, at + len);
    for (int i = 0; i < len; i++) begin
      if (at + i < log_n) begin
        check(log_src[at+i] == 2'(src), req, log_src[at+i], src);
        check(log_dir[at+i] == 2'(dir), req, log_dir[at+i], dir);
        check(log_flit[at+i][PW-1:0] == 8'(base + i), req, log_flit[at+i][PW-1:0], base + i);
        check(log_flit[at+i][FW-1] == (i == len - 1), req, log_flit[at+i][FW-1], i == len - 1);
      end
    end
  endtask

  task automatic route_case(int dx, int dy, logic [3:0] av, int ls, int exp, string req);
    int at;
    at = log_n;
    avail = av;
    local_side = 2'(ls);
    push_pkt(0, dx, dy, 1, 16'h40 + at);
    wait_cycles(5);
    expect_pkt(at, 0, exp, 1, 16'h40 + at, req);
  endtask

  task automatic t_reset();
    rst = 1;
    wait_cycles(3);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 4'hF, "R1", in_ready, 15);
    rst = 0;
    wait_cycles(1);
  endtask

  task automatic t_plain_xy();
    route_case(5, 1, 4'hF, 2, 1, "R2 east");
    route_case(1, 6, 4'hF, 2, 3, "R2 west");
    route_case(3, 6, 4'hF, 2, 0, "R2 north");
    route_case(3, 0, 4'hF, 2, 2, "R2 south");
  endtask

  task automatic t_local();
    route_case(3, 3, 4'hF, 3, 3, "R5 local west");
    route_case(3, 3, 4'h0, 0, 0, "R5 local north");
  endtask

  task automatic t_x_bypass();
    route_case(5, 6, 4'b1101, 2, 0, "R3 toward y north");
    route_case(1, 0, 4'b0111, 2, 2, "R3 toward y south");
    route_case(5, 3, 4'b1101, 2, 0, "R3 north first");
    route_case(5, 3, 4'b1100, 2, 2, "R3 south second");
    route_case(5, 3, 4'b0000, 2, 1, "R3 keep pref");
  endtask

  task automatic t_y_bypass();
    route_case(3, 6, 4'b1110, 2, 1, "R4 east first");
    route_case(3, 0, 4'b1000, 2, 3, "R4 west second");
    route_case(3, 6, 4'b0000, 2, 0, "R4 keep pref");
  endtask

  task automatic t_priority();
    int at;
    at = log_n;
    avail = 4'hF;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      in_valid = 4'hF;
      for (int s = 0; s < 4; s++)
        in_flit[s*FW +: FW] = {(i == 1), 3'(5), 3'(3), 8'(16 * s + i)};
    end
    @(negedge clk);
    in_valid = '0;
    wait_cycles(16);
    for (int s = 0; s < 4; s++) expect_pkt(at + 2 * s, s, 1, 2, 16 * s, "R7 priority");
  endtask

  task automatic t_hold();
    int at;
    at = log_n;
    push_pkt(3, 1, 3, 4, 8'h80);
    wait_cycles(1);
    push_pkt(0, 3, 6, 1, 8'h90);
    wait_cycles(10);
    expect_pkt(at, 3, 3, 4, 8'h80, "R8 hold");
    expect_pkt(at + 4, 0, 0, 1, 8'h90, "R8 after");
  endtask

  task automatic t_store_fwd();
    int at;
    at = log_n;
    push_pkt(1, 3, 0, 3, 8'hA0, 0);
    wait_cycles(10);
    check(log_n == at, "R6 no early flit", log_n, at);
    push_pkt(1, 3, 0, 1, 8'hA3);
    wait_cycles(8);
    expect_pkt(at, 1, 2, 4, 8'hA0, "R6 whole packet");
  endtask

  task automatic t_full();
    push_pkt(2, 5, 3, DEPTH, 8'hC0, 0);
    check(in_ready == 4'b1011, "R9 full", in_ready, 11);
    t_reset();
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_plain_xy();
    t_local();
    t_x_bypass();
    t_y_bypass();
    t_priority();
    t_hold();
    t_store_fwd();
    t_full();
    route_case(1, 3, 4'hF, 2, 3, "R2 after reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule